// File: doc/BRIEF.md
# Data Clock Loss Monitor

This block watches a source-synchronous data clock from a free-running reference clock. When the data clock stops, the block shuts down the converter output that depends on it. Each rising edge of the monitored clock flips a toggle flop in the monitored domain. The toggle crosses into the reference domain through a synchronizer, and a change in the synchronized value counts as one detected edge. A saturating counter measures how many reference cycles have passed since the last detected edge. When the counter reaches the timeout limit, the clock is declared lost.

On a loss, a live "clock absent" alarm and a sticky "clock was lost" alarm both rise, and `tx_off` is asserted. `tx_off` forces the downstream converter output to zero. When the clock returns, the absent alarm falls on its own. The lost alarm and `tx_off` stay set until a clear pulse arrives while the clock is present. A clear pulse given while the clock is still absent does nothing. After reset, `tx_off` is held until the first detected edge, and no alarm is raised while waiting for that edge.

The controller has four states:
- `MON_WAIT`: after reset.
- `MON_RUN`: the clock is healthy and the output is enabled.
- `MON_LOST`: the clock is absent.
- `MON_HELD`: the clock has returned but the shutdown is still latched.

It has six transitions:
- WAIT→RUN on the first edge.
- RUN→LOST on timeout.
- LOST→HELD on an edge.
- HELD→RUN on clear.
- HELD→LOST on timeout. Timeout has priority over clear.
- LOST stays in LOST while the clock is absent, whatever the clear input does.

Top module: `dclk_loss_mon`

## Requirements
- R1: After reset, `tx_off`=1, `alarm_absent`=0 and `alarm_lost`=0. These values hold for as long as no edge of the monitored clock is detected, with no alarm raised.
- R2: The first detected edge after reset deasserts `tx_off`. Alarms stay 0.
- R3: The edge counter restarts at 0 on every detected edge, counts reference cycles otherwise, and saturates at LIMIT (default 4) without wrapping. The clock is declared lost when the count reaches LIMIT, meaning LIMIT consecutive reference cycles passed with no detected edge. With monitored edges spaced G reference cycles apart, a loss occurs if and only if G ≥ LIMIT+1.
- R4: On a loss, `alarm_absent`=1, `alarm_lost`=1 and `tx_off`=1, all from the same cycle.
- R5: When edges resume after a loss, `alarm_absent` returns to 0, while `alarm_lost` and `tx_off` stay 1.
- R6: A clear pulse while `alarm_absent`=1 has no effect: all three outputs keep their values.
- R7: A clear pulse while the shutdown is latched and the clock is present deasserts `alarm_lost` and `tx_off` in the next cycle.
- R8: If a timeout and a clear pulse fall in the same reference cycle while latched, the timeout wins: the block goes to the absent/lost state, with all outputs 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| mon_clk | input | 1 | Monitored data clock |
| clr_alarm | input | 1 | Clear request for the latched shutdown, reference domain |
| alarm_absent | output | 1 | Clock currently absent |
| alarm_lost | output | 1 | Sticky: clock was lost since the last clear |
| tx_off | output | 1 | Forces the converter output to zero |

## Verification
The timeout and the clear request can land on the same reference cycle while the shutdown is latched. The bench provokes this by sending a single monitored edge to reach the latched state, then counting forward arithmetically to the cycle in which the counter reaches LIMIT, and raising clear for exactly that cycle. The result is judged at the ports. Timeout priority leaves all three outputs high. A clear that wrongly won would show `tx_off` low. A companion case pulses clear one cycle earlier, where the clear must win. The gap sweep over G=1..LIMIT+3 confirms the boundary G=LIMIT+1 arithmetically.

// File: rtl/dclm_pkg.sv
package dclm_pkg;

    typedef enum logic [1:0] {
        MON_WAIT = 2'd0,
        MON_RUN  = 2'd1,
        MON_LOST = 2'd2,
        MON_HELD = 2'd3
    } mon_state_t;

    typedef struct packed {
        logic tx_off;
        logic absent;
        logic lost;
    } mon_out_t;

endpackage

// File: rtl/dclm_toggle.sv
// Divides the monitored clock by two: one level change per rising edge.
module dclm_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tgl
);

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl <= 1'b0;
        end else begin
            tgl <= ~tgl;
        end
    end

endmodule

// File: rtl/dclm_sync.sv
// Multi-stage synchronizer into the reference domain.
module dclm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dclm_edge_timer.sv
// Detects changes of the synchronized toggle and times the gap between them.
module dclm_edge_timer #(
    parameter int LIMIT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(LIMIT + 1)
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             tgl_async,
    output logic             edge_seen,
    output logic [CNT_W-1:0] count,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic tgl_s;
    logic tgl_d;

    dclm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (tgl_async),
        .q     (tgl_s)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_d <= 1'b0;
        end else begin
            tgl_d <= tgl_s;
        end
    end

    assign edge_seen = tgl_s ^ tgl_d;

    // Reset to the saturated value: no edge has been seen yet.
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_MAX;
        end else if (edge_seen) begin
            count <= '0;
        end else if (count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    assign timeout = (count == CNT_MAX);

endmodule

// File: rtl/dclm_fsm.sv
// Shutdown controller: state register, next-state logic and output decode.
module dclm_fsm
    import dclm_pkg::*;
(
    input  logic     ref_clk,
    input  logic     rst_n,
    input  logic     edge_seen,
    input  logic     timeout,
    input  logic     clr,
    output mon_out_t outs
);

    mon_state_t state_q;
    mon_state_t state_d;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_WAIT: if (edge_seen) state_d = MON_RUN;
            MON_RUN:  if (timeout)   state_d = MON_LOST;
            MON_LOST: if (edge_seen) state_d = MON_HELD;
            MON_HELD: begin
                if (timeout) begin
                    state_d = MON_LOST;
                end else if (clr) begin
                    state_d = MON_RUN;
                end
            end
            default:  state_d = MON_WAIT;
        endcase
    end

    always_comb begin
        outs = '{tx_off: 1'b1, absent: 1'b0, lost: 1'b0};
        unique case (state_q)
            MON_WAIT: outs = '{tx_off: 1'b1, absent: 1'b0, lost: 1'b0};
            MON_RUN:  outs = '{tx_off: 1'b0, absent: 1'b0, lost: 1'b0};
            MON_LOST: outs = '{tx_off: 1'b1, absent: 1'b1, lost: 1'b1};
            MON_HELD: outs = '{tx_off: 1'b1, absent: 1'b0, lost: 1'b1};
            default:  outs = '{tx_off: 1'b1, absent: 1'b0, lost: 1'b0};
        endcase
    end

endmodule

// File: rtl/dclk_loss_mon.sv
module dclk_loss_mon
    import dclm_pkg::*;
#(
    parameter int LIMIT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic clr_alarm,
    output logic alarm_absent,
    output logic alarm_lost,
    output logic tx_off
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic             tgl;
    logic             edge_seen;
    logic [CNT_W-1:0] count;
    logic             timeout;
    mon_out_t         outs;

    dclm_toggle u_tgl (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .tgl     (tgl)
    );

    dclm_edge_timer #(
        .LIMIT       (LIMIT),
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .tgl_async (tgl),
        .edge_seen (edge_seen),
        .count     (count),
        .timeout   (timeout)
    );

    dclm_fsm u_fsm (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .edge_seen (edge_seen),
        .timeout   (timeout),
        .clr       (clr_alarm),
        .outs      (outs)
    );

    assign alarm_absent = outs.absent;
    assign alarm_lost   = outs.lost;
    assign tx_off       = outs.tx_off;

endmodule

// File: rtl/dclk_loss_mon_chk.sv
module dclk_loss_mon_chk #(
    parameter int LIMIT = 4,
    parameter int CNT_W = 3
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             clr_alarm,
    input logic             edge_seen,
    input logic             timeout,
    input logic [CNT_W-1:0] count,
    input logic             alarm_absent,
    input logic             alarm_lost,
    input logic             tx_off
);

    // R1
    enabled_clean_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !tx_off |-> (!alarm_lost && !alarm_absent));

    // R2
    first_edge_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (edge_seen && tx_off && !alarm_lost) |=> !tx_off);

    // R3
    count_sat_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        count <= CNT_W'(LIMIT));

    // R3
    count_restart_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        edge_seen |=> (count == '0));

    // R3
    run_timeout_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (timeout && !tx_off) |=> alarm_absent);

    // R4
    loss_all_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(alarm_lost) |-> (alarm_absent && tx_off));

    // R5
    held_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (alarm_lost && !alarm_absent) |-> tx_off);

    // R6
    absent_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (alarm_absent && !edge_seen) |=> (alarm_absent && alarm_lost && tx_off));

    // R7
    held_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (alarm_lost && !alarm_absent && clr_alarm && !timeout) |=> (!tx_off && !alarm_lost));

    // R8
    clash_prio_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (alarm_lost && !alarm_absent && clr_alarm && timeout) |=> (alarm_absent && tx_off));

endmodule

bind dclk_loss_mon dclk_loss_mon_chk #(
    .LIMIT (LIMIT),
    .CNT_W (CNT_W)
) u_chk (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .clr_alarm    (clr_alarm),
    .edge_seen    (edge_seen),
    .timeout      (timeout),
    .count        (count),
    .alarm_absent (alarm_absent),
    .alarm_lost   (alarm_lost),
    .tx_off       (tx_off)
);

// File: tb/sim_dclk_loss_mon.sv
module sim_dclk_loss_mon;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int LIM        = 4;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic mon_clk = 1'b0;
    logic clr_alarm = 1'b0;
    logic alarm_absent;
    logic alarm_lost;
    logic tx_off;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    dclk_loss_mon #(.LIMIT(LIM), .SYNC_STAGES(2)) u0 (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .mon_clk      (mon_clk),
        .clr_alarm    (clr_alarm),
        .alarm_absent (alarm_absent),
        .alarm_lost   (alarm_lost),
        .tx_off       (tx_off)
    );

    always #(HALF) ref_clk = ~ref_clk;

    task automatic expect3(input string req, input logic ea, input logic el, input logic et);
        n_chk++;
        if ({alarm_absent, alarm_lost, tx_off} !== {ea, el, et}) begin
            n_err++;
            $display("FAIL %s: absent/lost/tx_off got %b%b%b expected %b%b%b",
                     req, alarm_absent, alarm_lost, tx_off, ea, el, et);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge ref_clk);
    endtask

    // n monitored rising edges, each gap reference cycles after the previous,
    // placed half a reference period after a reference edge.
    task automatic run_gap(input int gap, input int n);
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(posedge ref_clk);
            #(HALF);
            mon_clk = 1'b1;
            #2;
            mon_clk = 1'b0;
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        mon_clk = 1'b0;
        clr_alarm = 1'b0;
        idle(3);
        #3;
        rst_n = 1'b1;
    endtask

    task automatic pulse_clr;
        @(posedge ref_clk);
        #3;
        clr_alarm = 1'b1;
        @(posedge ref_clk);
        #3;
        clr_alarm = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state and no alarm while waiting for a first edge
        do_reset();
        idle(2); #3;
        expect3("R1 reset", 1'b0, 1'b0, 1'b1);
        idle(LIM + 6); #3;
        expect3("R1 wait no edge", 1'b0, 1'b0, 1'b1);

        // R3: sweep of edge spacing G; loss expected iff G >= LIM+1
        for (int g = 1; g <= LIM + 3; g++) begin
            do_reset();
            run_gap(2, 5);
            expect3("R2 first edges enable", 1'b0, 1'b0, 1'b0);
            run_gap(g, 8);
            run_gap(2, 5);
            if (g >= LIM + 1) begin
                expect3("R3 gap loss then R5 held", 1'b0, 1'b1, 1'b1);
                pulse_clr();
                expect3("R7 clear in held", 1'b0, 1'b0, 1'b0);
            end else begin
                expect3("R3 gap no loss", 1'b0, 1'b0, 1'b0);
            end
        end

        // R4 / R6: stop the clock, clear while absent
        do_reset();
        run_gap(2, 5);
        idle(LIM + 8); #3;
        expect3("R4 loss", 1'b1, 1'b1, 1'b1);
        pulse_clr();
        idle(2); #3;
        expect3("R6 clear while absent", 1'b1, 1'b1, 1'b1);
        idle(300); #3;
        expect3("R3 long absence saturates", 1'b1, 1'b1, 1'b1);

        // R5 / R7: clock returns, then clear
        run_gap(2, 5);
        expect3("R5 clock back, still latched", 1'b0, 1'b1, 1'b1);
        pulse_clr();
        expect3("R7 clear releases", 1'b0, 1'b0, 1'b0);

        // R8: timeout and clear in the same cycle while latched
        idle(LIM + 8); #3;
        expect3("R4 loss again", 1'b1, 1'b1, 1'b1);
        run_gap(1, 1);                 // single edge, pulse after posedge a
        idle(3); #3;                   // edge detected at a+3 -> held
        expect3("R5 held after single edge", 1'b0, 1'b1, 1'b1);
        idle(LIM); #3;                 // now after a+3+LIM, timeout visible
        clr_alarm = 1'b1;
        @(posedge ref_clk); #3;        // a+4+LIM: timeout and clear together
        clr_alarm = 1'b0;
        expect3("R8 timeout beats clear", 1'b1, 1'b1, 1'b1);

        // R7 one cycle before the timeout: clear wins, then the loss follows
        run_gap(1, 1);
        idle(3); #3;
        expect3("R5 held before early clear", 1'b0, 1'b1, 1'b1);
        idle(LIM - 1); #3;             // after a+2+LIM, count is LIM-1
        clr_alarm = 1'b1;
        @(posedge ref_clk); #3;        // a+3+LIM: clear only
        clr_alarm = 1'b0;
        expect3("R7 early clear wins", 1'b0, 1'b0, 1'b0);
        @(posedge ref_clk); #3;        // a+4+LIM: timeout in run
        expect3("R4 loss after early clear", 1'b1, 1'b1, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule